// File: doc/BRIEF.md
# Fetch-Stage Loop Buffer

This block sits inside an instruction fetch stage and keeps a short run of the most recently fetched instruction words. The words have consecutive addresses. It records the window as a base address and a count of valid words. Every accepted fetch is compared against that window in the same cycle. If the address lies inside the window, the word is read from the local store and no memory request is made. If the address lies outside, the request goes to instruction memory and the returned word is added to the window.

A fetch flagged as a taken-branch target that misses throws away the old window and starts a new one at the target. A sequential miss that continues the window on from its last address extends it. When the store is full, the oldest word drops out and the base moves up by one. Branches back to a loop head inside the window hit, and so do short forward branches into words already fetched. A small loop therefore runs from the store without touching memory. The window is kept modulo the address width, so it may span the top of the address space and continue at zero.

At most one memory miss is outstanding. While it is pending the block lowers its ready output, and the fetch stage holds off until the word has come back.

Top module: `loop_buffer`

## Requirements
- R1: After a synchronous reset the window is empty: `insn_valid_o` is 0, `fetch_rdy_o` is 1, and the first fetch at any address misses.
- R2: An accepted fetch (`fetch_req_i` and `fetch_rdy_o`) whose address is outside the window raises `mem_req_o` in that same cycle, with `mem_addr_o` equal to the fetch address. `mem_req_o` is never high in any other case.
- R3: One cycle after `mem_rsp_valid_i` is high for a pending miss, `insn_valid_o` is 1, `insn_hit_o` is 0, `insn_o` equals the response word and `insn_addr_o` equals the missed address.
- R4: `fetch_rdy_o` is 0 from the cycle after a miss request up to and including the cycle of its response, and is 1 again in the cycle after the response.
- R5: An accepted fetch at address A hits when (A - base) modulo 2^AW is less than count. It then makes no memory request, and in the next cycle `insn_valid_o`=1, `insn_hit_o`=1, `insn_addr_o`=A, and `insn_o` holds the word stored for A.
- R6: A sequential miss (`fetch_branch_i`=0) at address base+count appends the returned word to the window. While count is below DEPTH the count grows by one. At count DEPTH the oldest word is evicted and base advances by one, so base itself then misses.
- R7: A branch-flagged fetch that misses restarts the window at its address, even when that address equals base+count. Every earlier address misses afterwards until it is fetched again.
- R8: A sequential miss at any address other than base+count also restarts the window at that address.
- R9: The window may span the wrap from the largest address to zero, and hits are decided by the modulo range test on both sides of the wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_req_i | input | 1 | Fetch request from the fetch stage |
| fetch_addr_i | input | AW | Word address being fetched |
| fetch_branch_i | input | 1 | Fetch is a taken-branch target |
| fetch_rdy_o | output | 1 | Block can accept a fetch (no miss pending) |
| mem_req_o | output | 1 | Instruction memory read request |
| mem_addr_o | output | AW | Instruction memory read address |
| mem_rsp_valid_i | input | 1 | Memory returns the missed word |
| mem_rsp_data_i | input | DW | Returned instruction word |
| insn_valid_o | output | 1 | Instruction output valid |
| insn_addr_o | output | AW | Address of the delivered instruction |
| insn_o | output | DW | Delivered instruction word |
| insn_hit_o | output | 1 | Delivered word came from the buffer |

## Verification
A wrong base or count shows at the ports in the same cycle as the next fetch into the affected range. `mem_req_o` is then raised where a hit was due, or held low where a miss was due, so a window error surfaces on the first fetch that touches it. A wrong store slot or a corrupted word shows one cycle later as a mismatched `insn_o` on a hit, because every memory word is a distinct function of its address. Loops that refill the window past DEPTH, restarts on branches and on gaps, and a window spanning the wrap to zero each drive the boundary of the range test.

// File: rtl/lb_pkg.sv
package lb_pkg;
  localparam int unsigned LB_AW    = 16;
  localparam int unsigned LB_DW    = 32;
  localparam int unsigned LB_DEPTH = 8;

  // Window update selected by the top level each cycle
  typedef enum logic [1:0] {
    WIN_HOLD    = 2'd0,
    WIN_RESTART = 2'd1,
    WIN_APPEND  = 2'd2
  } win_op_e;
endpackage

// File: rtl/lb_window.sv
module lb_window
  import lb_pkg::*;
#(
  parameter int unsigned AW    = LB_AW,
  parameter int unsigned DEPTH = LB_DEPTH,
  localparam int unsigned CW   = $clog2(DEPTH) + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] probe_addr_i,
  input  win_op_e       op_i,
  input  logic [AW-1:0] restart_addr_i,
  output logic          hit_o,
  output logic [AW-1:0] tail_o,
  output logic [CW-1:0] cnt_o
);
  logic [AW-1:0] base_q;
  logic [CW-1:0] cnt_q;
  logic [AW-1:0] offset;
  logic          full;

  // Modulo distance from the base; wraps through zero naturally
  assign offset = probe_addr_i - base_q;
  assign hit_o  = ({{(AW > CW ? AW - CW : 0){1'b0}}, cnt_q} > offset);
  assign tail_o = base_q + AW'(cnt_q);
  assign full   = (cnt_q == CW'(DEPTH));
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= '0;
      cnt_q  <= '0;
    end else begin
      unique case (op_i)
        WIN_RESTART: begin
          base_q <= restart_addr_i;
          cnt_q  <= '0;
        end
        WIN_APPEND: begin
          if (full) base_q <= base_q + AW'(1);
          else      cnt_q  <= cnt_q + CW'(1);
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/lb_store.sv
module lb_store
  import lb_pkg::*;
#(
  parameter int unsigned DW    = LB_DW,
  parameter int unsigned DEPTH = LB_DEPTH,
  localparam int unsigned IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          we_i,
  input  logic [IW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          re_i,
  input  logic [IW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  // Simple dual-port array, synchronous read
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we_i) mem[waddr_i] <= wdata_i;
  end

  always_ff @(posedge clk) begin
    if (re_i) rdata_o <= mem[raddr_i];
  end
endmodule

// File: rtl/lb_miss.sv
module lb_miss
  import lb_pkg::*;
#(
  parameter int unsigned AW = LB_AW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          issue_i,
  input  logic [AW-1:0] issue_addr_i,
  input  logic          rsp_i,
  output logic          busy_o,
  output logic          done_o,
  output logic [AW-1:0] paddr_o
);
  logic          busy_q;
  logic [AW-1:0] paddr_q;

  assign busy_o  = busy_q;
  assign done_o  = busy_q & rsp_i;
  assign paddr_o = paddr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q  <= 1'b0;
      paddr_q <= '0;
    end else if (issue_i) begin
      busy_q  <= 1'b1;
      paddr_q <= issue_addr_i;
    end else if (done_o) begin
      busy_q  <= 1'b0;
    end
  end
endmodule

// File: rtl/loop_buffer.sv
module loop_buffer
  import lb_pkg::*;
#(
  parameter int unsigned AW    = LB_AW,
  parameter int unsigned DW    = LB_DW,
  parameter int unsigned DEPTH = LB_DEPTH
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          fetch_req_i,
  input  logic [AW-1:0] fetch_addr_i,
  input  logic          fetch_branch_i,
  output logic          fetch_rdy_o,
  output logic          mem_req_o,
  output logic [AW-1:0] mem_addr_o,
  input  logic          mem_rsp_valid_i,
  input  logic [DW-1:0] mem_rsp_data_i,
  output logic          insn_valid_o,
  output logic [AW-1:0] insn_addr_o,
  output logic [DW-1:0] insn_o,
  output logic          insn_hit_o
);
  localparam int unsigned IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH) + 1;

  logic          busy, done;
  logic [AW-1:0] paddr;
  logic          win_hit;
  logic [AW-1:0] win_tail;
  logic [CW-1:0] win_cnt;
  win_op_e       win_op;
  logic          accept, hit, miss, restart;
  logic [DW-1:0] rd_word;

  logic          vld_q, hit_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] rsp_q;

  assign fetch_rdy_o = ~busy;
  assign accept      = fetch_req_i & ~busy;
  assign hit         = accept & win_hit;
  assign miss        = accept & ~win_hit;
  // A branch miss or a gap in the sequence opens a fresh window
  assign restart     = miss & (fetch_branch_i | (fetch_addr_i != win_tail));

  always_comb begin
    win_op = WIN_HOLD;
    if (restart)   win_op = WIN_RESTART;
    else if (done) win_op = WIN_APPEND;
  end

  assign mem_req_o  = miss;
  assign mem_addr_o = fetch_addr_i;

  lb_window #(.AW(AW), .DEPTH(DEPTH)) u_win (
    .clk           (clk),
    .rst           (rst),
    .probe_addr_i  (fetch_addr_i),
    .op_i          (win_op),
    .restart_addr_i(fetch_addr_i),
    .hit_o         (win_hit),
    .tail_o        (win_tail),
    .cnt_o         (win_cnt)
  );

  lb_miss #(.AW(AW)) u_miss (
    .clk         (clk),
    .rst         (rst),
    .issue_i     (miss),
    .issue_addr_i(fetch_addr_i),
    .rsp_i       (mem_rsp_valid_i),
    .busy_o      (busy),
    .done_o      (done),
    .paddr_o     (paddr)
  );

  // Window is contiguous and no longer than DEPTH, so address bits pick a unique slot
  lb_store #(.DW(DW), .DEPTH(DEPTH)) u_store (
    .clk    (clk),
    .we_i   (done),
    .waddr_i(paddr[IW-1:0]),
    .wdata_i(mem_rsp_data_i),
    .re_i   (hit),
    .raddr_i(fetch_addr_i[IW-1:0]),
    .rdata_o(rd_word)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q  <= 1'b0;
      hit_q  <= 1'b0;
      addr_q <= '0;
      rsp_q  <= '0;
    end else begin
      vld_q <= hit | done;
      hit_q <= hit;
      if (hit)  addr_q <= fetch_addr_i;
      if (done) begin
        addr_q <= paddr;
        rsp_q  <= mem_rsp_data_i;
      end
    end
  end

  assign insn_valid_o = vld_q;
  assign insn_hit_o   = hit_q;
  assign insn_addr_o  = addr_q;
  assign insn_o       = hit_q ? rd_word : rsp_q;
endmodule

// File: rtl/lb_chk.sv
module lb_chk #(
  parameter int unsigned AW    = 16,
  parameter int unsigned DW    = 32,
  parameter int unsigned DEPTH = 8,
  localparam int unsigned CW   = $clog2(DEPTH) + 1
) (
  input logic          clk,
  input logic          rst,
  input logic          fetch_req_i,
  input logic [AW-1:0] fetch_addr_i,
  input logic          fetch_branch_i,
  input logic          fetch_rdy_o,
  input logic          mem_req_o,
  input logic          mem_rsp_valid_i,
  input logic [DW-1:0] mem_rsp_data_i,
  input logic          insn_valid_o,
  input logic [AW-1:0] insn_addr_o,
  input logic [DW-1:0] insn_o,
  input logic          insn_hit_o,
  input logic [CW-1:0] cnt_i
);
  p_reset_empty_r1: assert property (@(posedge clk)
    rst |=> (!insn_valid_o && fetch_rdy_o && cnt_i == '0));

  p_req_only_when_free_r2: assert property (@(posedge clk) disable iff (rst)
    (mem_req_o |-> (fetch_req_i && fetch_rdy_o)));

  p_rsp_delivered_r3: assert property (@(posedge clk) disable iff (rst)
    (mem_rsp_valid_i && !fetch_rdy_o) |=>
      (insn_valid_o && !insn_hit_o && insn_o == $past(mem_rsp_data_i)));

  p_stall_after_miss_r4: assert property (@(posedge clk) disable iff (rst)
    mem_req_o |=> !fetch_rdy_o);

  p_ready_after_rsp_r4: assert property (@(posedge clk) disable iff (rst)
    (mem_rsp_valid_i && !fetch_rdy_o) |=> fetch_rdy_o);

  p_hit_from_store_r5: assert property (@(posedge clk) disable iff (rst)
    (fetch_req_i && fetch_rdy_o && !mem_req_o) |=>
      (insn_valid_o && insn_hit_o && insn_addr_o == $past(fetch_addr_i)));

  p_count_bounded_r6: assert property (@(posedge clk) disable iff (rst)
    cnt_i <= CW'(DEPTH));

  p_branch_restart_r7: assert property (@(posedge clk) disable iff (rst)
    (mem_req_o && fetch_branch_i) |=> cnt_i == '0);
endmodule

bind loop_buffer lb_chk #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) u_chk (
  .clk            (clk),
  .rst            (rst),
  .fetch_req_i    (fetch_req_i),
  .fetch_addr_i   (fetch_addr_i),
  .fetch_branch_i (fetch_branch_i),
  .fetch_rdy_o    (fetch_rdy_o),
  .mem_req_o      (mem_req_o),
  .mem_rsp_valid_i(mem_rsp_valid_i),
  .mem_rsp_data_i (mem_rsp_data_i),
  .insn_valid_o   (insn_valid_o),
  .insn_addr_o    (insn_addr_o),
  .insn_o         (insn_o),
  .insn_hit_o     (insn_hit_o),
  .cnt_i          (win_cnt)
);

// File: tb/sim_loop_buffer.sv
`timescale 1ns/1ps
module sim_loop_buffer;
  localparam int AW    = 16;
  localparam int DW    = 32;
  localparam int DEPTH = 8;
  localparam int MASK  = (1 << AW) - 1;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          fetch_req_i = 1'b0;
  logic [AW-1:0] fetch_addr_i = '0;
  logic          fetch_branch_i = 1'b0;
  logic          fetch_rdy_o;
  logic          mem_req_o;
  logic [AW-1:0] mem_addr_o;
  logic          mem_rsp_valid_i = 1'b0;
  logic [DW-1:0] mem_rsp_data_i = '0;
  logic          insn_valid_o;
  logic [AW-1:0] insn_addr_o;
  logic [DW-1:0] insn_o;
  logic          insn_hit_o;

  always #4 clk = ~clk;   // 125 MHz

  loop_buffer #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) u0 (.*);

  int vectors = 0;
  int errors  = 0;
  bit done    = 0;

  // Reference model state
  int m_base = 0, m_cnt = 0, m_paddr = 0;
  bit m_pend = 0;
  bit e_vld = 0, e_hit = 0;
  int e_addr = 0;

  function automatic logic [DW-1:0] word(int a);
    return DW'((a & MASK) * 32'h2545F491) ^ 32'h5A5A0F0F;
  endfunction

  function automatic bit in_window(int a);
    return ((a - m_base) & MASK) < m_cnt;
  endfunction

  task automatic cyc(bit req, int a, bit br, bit rv, string tag);
    bit acc, h, ereq, ok;
    @(negedge clk);
    fetch_req_i     = req;
    fetch_addr_i    = AW'(a);
    fetch_branch_i  = br;
    mem_rsp_valid_i = rv;
    mem_rsp_data_i  = rv ? word(m_paddr) : '0;
    #1;
    acc  = req && !m_pend;
    h    = acc && in_window(a);
    ereq = acc && !h;
    ok = (fetch_rdy_o == !m_pend) && (mem_req_o == ereq) && (insn_valid_o == e_vld);
    if (ereq && mem_addr_o != AW'(a)) ok = 0;
    if (e_vld && (insn_hit_o != e_hit || insn_addr_o != AW'(e_addr) || insn_o != word(e_addr))) ok = 0;
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s t=%0t: got rdy=%0b req=%0b maddr=%h vld=%0b hit=%0b addr=%h insn=%h | exp rdy=%0b req=%0b maddr=%h vld=%0b hit=%0b addr=%h insn=%h",
               tag, $time, fetch_rdy_o, mem_req_o, mem_addr_o, insn_valid_o, insn_hit_o, insn_addr_o, insn_o,
               !m_pend, ereq, AW'(a), e_vld, e_hit, AW'(e_addr), word(e_addr));
    end
    // advance model to the next edge
    e_vld = 0; e_hit = 0;
    if (h) begin
      e_vld = 1; e_hit = 1; e_addr = a & MASK;
    end else if (ereq) begin
      if (br || (a & MASK) != ((m_base + m_cnt) & MASK)) begin
        m_base = a & MASK; m_cnt = 0;
      end
      m_pend = 1; m_paddr = a & MASK;
    end else if (rv && m_pend) begin
      if (m_cnt == DEPTH) m_base = (m_base + 1) & MASK;
      else m_cnt++;
      m_pend = 0; e_vld = 1; e_hit = 0; e_addr = m_paddr;
    end
  endtask

  task automatic fetch(int a, bit br, int lat, string tag);
    bit h;
    h = in_window(a);
    cyc(1, a, br, 0, tag);
    if (!h) begin
      for (int i = 0; i < lat; i++) cyc(0, 0, 0, 0, tag);
      cyc(0, 0, 0, 1, tag);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: empty after reset, outputs idle
    cyc(0, 0, 0, 0, "R1 reset state");
    fetch(16'h0100, 1, 0, "R1 R2 R3 first fetch misses");
    // R6: sequential fill up to DEPTH, varying latency
    for (int i = 1; i < DEPTH; i++) fetch(16'h0100 + i, 0, i % 4, "R4 R6 fill");
    cyc(0, 0, 0, 0, "R3 idle after fill");
    // R5: backward branch to loop head, whole loop from the store
    fetch(16'h0100, 1, 0, "R5 backward branch hit");
    for (int i = 1; i < DEPTH; i++) fetch(16'h0100 + i, 0, 0, "R5 loop body hit");
    // R6: append at full window evicts oldest
    fetch(16'h0108, 0, 2, "R6 append evicts");
    fetch(16'h0101, 1, 0, "R6 new base hits");
    fetch(16'h0100, 1, 1, "R6 evicted base misses");
    // R7: branch miss restarted at 0x100; 0x105 now outside
    fetch(16'h0105, 1, 0, "R7 old words gone");
    // R7: branch to exactly base+count restarts instead of extending
    fetch(16'h0106, 1, 0, "R7 branch at tail restarts");
    fetch(16'h0105, 1, 0, "R7 word before restart misses");
    // R5: forward branch into prefetched words
    for (int i = 0; i < 6; i++) fetch(16'h0200 + i, i == 0, 1, "R6 refill");
    fetch(16'h0201, 1, 0, "R5 backward hit");
    fetch(16'h0204, 1, 0, "R5 forward branch hit");
    fetch(16'h0205, 0, 0, "R5 sequential hit");
    // R8: sequential gap restarts the window
    fetch(16'h0300, 0, 3, "R8 gap miss");
    fetch(16'h0201, 0, 0, "R8 old window gone");
    fetch(16'h0300, 1, 0, "R8 restarted word lost");
    fetch(16'h0301, 0, 0, "R8 contiguous append");
    fetch(16'h0300, 1, 0, "R8 restarted base hits");
    // R9: window across the top of the address space
    fetch(16'hFFFD, 1, 0, "R9 start near top");
    for (int i = 1; i < 6; i++) fetch((16'hFFFD + i) & MASK, 0, i % 3, "R9 fill across wrap");
    fetch(16'hFFFE, 1, 0, "R9 hit below wrap");
    fetch(16'h0001, 1, 0, "R9 hit above wrap");
    fetch(16'h0002, 0, 0, "R9 last word hits");
    fetch(16'hFFFC, 1, 0, "R9 just below base misses");
    cyc(0, 0, 0, 0, "R3 final idle");
    cyc(0, 0, 0, 0, "R3 final idle");
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got running, expected finished");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule